// File: doc/BRIEF.md
# Bus Role Controller for a Processor Module

This block is the glue that lets one processor module sit on a shared multi-master bus in one of two roles, chosen by a static strap. In the arbiter role the module runs the bus's DMA arbitration, owns the bus init line and services the bus interrupt request lines. In the auxiliary role the arbitration logic is switched off. The module takes its grant from the bus grant-in pin, asserts the select-acknowledge line, passes interrupt acknowledge down the daisy chain, and treats a received bus init as a local clear.

Both roles request the bus the same way. The strap also decides which halt source counts when the active-low halt enable pin is asserted: the bus halt line for the arbiter, the register halt bit for an auxiliary. An auxiliary whose halt enable is negated turns its halt bit into a reboot request. Every bus-facing output is an active-high enable for an open-collector driver. All outputs are registered, so each one follows its inputs by one clock.

Top module: `bus_role_ctrl`

## Requirements
- R1: In both roles `bus_req_o` equals `dma_req_i` from the previous cycle. After reset every output is low.
- R2: In the arbiter role the internal grant is chosen among requesters in the vector {`ext_req_i`, `dma_req_i`}. Index 0 is the local request and has the highest priority; index i+1 is `ext_req_i[i]`. A grant is held while its requester keeps requesting. `ext_gnt_o[i]` carries the grant of index i+1, and at most one bit is set. In the auxiliary role `ext_gnt_o` stays zero.
- R3: `local_gnt_o` follows `bus_gnt_in_i` in the auxiliary role. In the arbiter role it is the internal grant of index 0, and `bus_gnt_in_i` has no effect.
- R4: `bus_sack_o` is high only in the auxiliary role, one cycle after `bus_gnt_in_i` and `dma_req_i` are both high. The arbiter never drives it.
- R5: In the arbiter role `bus_init_o` is high in the cycle after `dcok_i` is low. A cycle with `bir_wr_i` high makes `bus_init_o` high for exactly INIT_LEN cycles, starting the next cycle. In this role `sys_clr_o` equals `bus_init_o`.
- R6: In the auxiliary role `bus_init_o` is never driven and `bir_wr_i` has no effect. `sys_clr_o` is high one cycle after `bus_init_i` is high or `dcok_i` is low.
- R7: `iack_out_o` follows `iack_local_i` in the arbiter role and `iack_in_i` in the auxiliary role, one cycle later.
- R8: `irq_acc_o` bits 0..3 carry bus request lines 4..7 (`irq_bus_i[0..3]`) and are forced low in the auxiliary role. Bit 4 (timer), bit 5 (console) and bit 6 (doorbell) are accepted in both roles.
- R9: In the arbiter role `halt_req_o` is `bus_halt_i` while `halt_en_n_i` is low, and `reg_halt_i` has no effect. `reboot_req_o` stays low.
- R10: In the auxiliary role `halt_req_o` is `reg_halt_i` while `halt_en_n_i` is low, and `bus_halt_i` has no effect. With `halt_en_n_i` high, `reg_halt_i` drives `reboot_req_o` instead. The two are never high together.
- R11: While a local clear is active (`sys_clr_o` high in the next cycle), the internal grant is dropped to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| role_aux_i | input | 1 | Strap: 1 selects auxiliary, 0 arbiter |
| dma_req_i | input | 1 | Local DMA request |
| ext_req_i | input | NUM_EXT | DMA requests from other bus masters (arbiter role) |
| bus_gnt_in_i | input | 1 | Bus grant-in pin |
| bus_init_i | input | 1 | Received bus init |
| dcok_i | input | 1 | DC power good, low when negated |
| bir_wr_i | input | 1 | Write strobe of the bus initialize register |
| iack_in_i | input | 1 | Daisy-chain interrupt acknowledge in |
| iack_local_i | input | 1 | Local decision to acknowledge a bus interrupt |
| irq_bus_i | input | NUM_BUS_IRQ | Bus interrupt request lines 4..7 |
| irq_timer_i | input | 1 | Interval timer interrupt |
| irq_console_i | input | 1 | Console interrupt |
| irq_doorbell_i | input | 1 | Doorbell interrupt |
| bus_halt_i | input | 1 | Bus halt line |
| halt_en_n_i | input | 1 | Halt enable, active low |
| reg_halt_i | input | 1 | Halt bit from the communication register |
| bus_req_o | output | 1 | DMA request line driver enable |
| bus_sack_o | output | 1 | Select-acknowledge driver enable |
| bus_init_o | output | 1 | Bus init driver enable |
| iack_out_o | output | 1 | Interrupt acknowledge out driver enable |
| local_gnt_o | output | 1 | Grant to the local DMA master |
| ext_gnt_o | output | NUM_EXT | Grants to other bus masters |
| sys_clr_o | output | 1 | Local clear of the module |
| irq_acc_o | output | NUM_BUS_IRQ+3 | Accepted interrupt sources |
| halt_req_o | output | 1 | Halt request to the processor |
| reboot_req_o | output | 1 | Reboot request to the processor |

## Verification
On every cycle the assertions check role exclusivity: an auxiliary never drives init, the arbiter never drives select-acknowledge or requests a reboot, and halt and reboot are never raised together. They also check the one-cycle follow of the DMA request and of the chained acknowledge, the init drive after a power-good drop, and that at most one external grant is set. Only the bench scenarios can show the arbitration order and grant holding, the exact length of the init pulse after a register write, the grant being dropped during a clear, and which inputs each role ignores. They also cover the interrupt masks and halt-source selection under both straps.

// File: rtl/bus_role_pkg.sv
package bus_role_pkg;

    typedef enum logic {
        ROLE_ARB = 1'b0,
        ROLE_AUX = 1'b1
    } role_e;

    // offsets of the always-accepted sources above the bus lines
    localparam int unsigned IRQ_TIMER_OFS    = 0;
    localparam int unsigned IRQ_CONSOLE_OFS  = 1;
    localparam int unsigned IRQ_DOORBELL_OFS = 2;
    localparam int unsigned IRQ_LOCAL_CNT    = 3;

endpackage

// File: rtl/bus_role_prio_arb.sv
// Fixed-priority arbiter next-state logic with grant hold.
module bus_role_prio_arb #(
    parameter int unsigned N = 4
) (
    input  logic         enable_i,
    input  logic         clr_i,
    input  logic [N-1:0] req_i,
    input  logic [N-1:0] cur_i,
    output logic [N-1:0] nxt_o
);
    always_comb begin
        nxt_o = '0;
        if (enable_i && !clr_i) begin
            if ((cur_i & req_i) != '0) begin
                nxt_o = cur_i;
            end else begin
                // walk downwards so the lowest requesting index wins
                for (int i = N - 1; i >= 0; i--) begin
                    if (req_i[i]) begin
                        nxt_o = '0;
                        nxt_o[i] = 1'b1;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/bus_role_init_gen.sv
// Init drive timing and local clear selection.
module bus_role_init_gen #(
    parameter int unsigned INIT_LEN = 4,
    parameter int unsigned CW       = 3
) (
    input  logic          role_aux_i,
    input  logic          dcok_i,
    input  logic          bir_wr_i,
    input  logic          bus_init_i,
    input  logic [CW-1:0] cnt_q_i,
    output logic [CW-1:0] cnt_d_o,
    output logic          init_drv_d_o,
    output logic          clr_d_o
);
    always_comb begin
        cnt_d_o      = '0;
        init_drv_d_o = 1'b0;
        clr_d_o      = 1'b0;
        if (!role_aux_i) begin
            if (!dcok_i || bir_wr_i) begin
                cnt_d_o = CW'(INIT_LEN);
            end else if (cnt_q_i != '0) begin
                cnt_d_o = cnt_q_i - 1'b1;
            end
            init_drv_d_o = (cnt_d_o != '0);
            clr_d_o      = init_drv_d_o;
        end else begin
            clr_d_o = !dcok_i || bus_init_i;
        end
    end
endmodule

// File: rtl/bus_role_irq_sel.sv
// Selects the interrupt sources the module accepts in its role.
module bus_role_irq_sel
    import bus_role_pkg::*;
#(
    parameter int unsigned NB = 4,
    localparam int unsigned AW = NB + IRQ_LOCAL_CNT
) (
    input  logic          role_aux_i,
    input  logic [NB-1:0] irq_bus_i,
    input  logic          irq_timer_i,
    input  logic          irq_console_i,
    input  logic          irq_doorbell_i,
    output logic [AW-1:0] acc_o
);
    for (genvar g = 0; g < NB; g++) begin : g_bus_line
        assign acc_o[g] = irq_bus_i[g] & ~role_aux_i;
    end
    assign acc_o[NB + IRQ_TIMER_OFS]    = irq_timer_i;
    assign acc_o[NB + IRQ_CONSOLE_OFS]  = irq_console_i;
    assign acc_o[NB + IRQ_DOORBELL_OFS] = irq_doorbell_i;
endmodule

// File: rtl/bus_role_ctrl.sv
module bus_role_ctrl
    import bus_role_pkg::*;
#(
    parameter int unsigned NUM_EXT     = 3,
    parameter int unsigned NUM_BUS_IRQ = 4,
    parameter int unsigned INIT_LEN    = 4
) (
    input  logic                     clk_i,
    input  logic                     rst_ni,
    input  logic                     role_aux_i,
    input  logic                     dma_req_i,
    input  logic [NUM_EXT-1:0]       ext_req_i,
    input  logic                     bus_gnt_in_i,
    input  logic                     bus_init_i,
    input  logic                     dcok_i,
    input  logic                     bir_wr_i,
    input  logic                     iack_in_i,
    input  logic                     iack_local_i,
    input  logic [NUM_BUS_IRQ-1:0]   irq_bus_i,
    input  logic                     irq_timer_i,
    input  logic                     irq_console_i,
    input  logic                     irq_doorbell_i,
    input  logic                     bus_halt_i,
    input  logic                     halt_en_n_i,
    input  logic                     reg_halt_i,
    output logic                     bus_req_o,
    output logic                     bus_sack_o,
    output logic                     bus_init_o,
    output logic                     iack_out_o,
    output logic                     local_gnt_o,
    output logic [NUM_EXT-1:0]       ext_gnt_o,
    output logic                     sys_clr_o,
    output logic [NUM_BUS_IRQ+2:0]   irq_acc_o,
    output logic                     halt_req_o,
    output logic                     reboot_req_o
);
    localparam int unsigned NREQ = NUM_EXT + 1;
    localparam int unsigned CW   = $clog2(INIT_LEN + 1);
    localparam int unsigned AW   = NUM_BUS_IRQ + IRQ_LOCAL_CNT;

    typedef struct packed {
        logic [NREQ-1:0] gnt;
        logic [CW-1:0]   cnt;
        logic            bus_req;
        logic            sack;
        logic            init_drv;
        logic            clr;
        logic            iack;
        logic            local_gnt;
        logic [AW-1:0]   irq;
        logic            halt;
        logic            reboot;
    } state_t;

    state_t s_d, s_q;
    role_e  role;

    logic [NREQ-1:0] arb_nxt;
    logic [CW-1:0]   cnt_d;
    logic            init_drv_d;
    logic            clr_d;
    logic [AW-1:0]   irq_acc_d;

    assign role = role_aux_i ? ROLE_AUX : ROLE_ARB;

    bus_role_init_gen #(.INIT_LEN(INIT_LEN), .CW(CW)) i_init (
        .role_aux_i   (role_aux_i),
        .dcok_i       (dcok_i),
        .bir_wr_i     (bir_wr_i),
        .bus_init_i   (bus_init_i),
        .cnt_q_i      (s_q.cnt),
        .cnt_d_o      (cnt_d),
        .init_drv_d_o (init_drv_d),
        .clr_d_o      (clr_d)
    );

    bus_role_prio_arb #(.N(NREQ)) i_arb (
        .enable_i (role == ROLE_ARB),
        .clr_i    (clr_d),
        .req_i    ({ext_req_i, dma_req_i}),
        .cur_i    (s_q.gnt),
        .nxt_o    (arb_nxt)
    );

    bus_role_irq_sel #(.NB(NUM_BUS_IRQ)) i_irq (
        .role_aux_i     (role_aux_i),
        .irq_bus_i      (irq_bus_i),
        .irq_timer_i    (irq_timer_i),
        .irq_console_i  (irq_console_i),
        .irq_doorbell_i (irq_doorbell_i),
        .acc_o          (irq_acc_d)
    );

    always_comb begin
        s_d          = '0;
        s_d.bus_req  = dma_req_i;
        s_d.cnt      = cnt_d;
        s_d.init_drv = init_drv_d;
        s_d.clr      = clr_d;
        s_d.gnt      = arb_nxt;
        s_d.irq      = irq_acc_d;
        if (role == ROLE_AUX) begin
            s_d.local_gnt = bus_gnt_in_i;
            s_d.sack      = bus_gnt_in_i & dma_req_i;
            s_d.iack      = iack_in_i;
            s_d.halt      = !halt_en_n_i & reg_halt_i;
            s_d.reboot    = halt_en_n_i & reg_halt_i;
        end else begin
            s_d.local_gnt = arb_nxt[0];
            s_d.sack      = 1'b0;
            s_d.iack      = iack_local_i;
            s_d.halt      = !halt_en_n_i & bus_halt_i;
            s_d.reboot    = 1'b0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign bus_req_o    = s_q.bus_req;
    assign bus_sack_o   = s_q.sack;
    assign bus_init_o   = s_q.init_drv;
    assign iack_out_o   = s_q.iack;
    assign local_gnt_o  = s_q.local_gnt;
    assign ext_gnt_o    = s_q.gnt[NREQ-1:1];
    assign sys_clr_o    = s_q.clr;
    assign irq_acc_o    = s_q.irq;
    assign halt_req_o   = s_q.halt;
    assign reboot_req_o = s_q.reboot;
endmodule

// File: rtl/bus_role_chk.sv
module bus_role_chk #(
    parameter int unsigned NUM_EXT = 3
) (
    input logic               clk_i,
    input logic               rst_ni,
    input logic               role_aux_i,
    input logic               dma_req_i,
    input logic               dcok_i,
    input logic               iack_in_i,
    input logic               bus_req_o,
    input logic               bus_sack_o,
    input logic               bus_init_o,
    input logic               iack_out_o,
    input logic [NUM_EXT-1:0] ext_gnt_o,
    input logic               halt_req_o,
    input logic               reboot_req_o
);
    assert_req_follow_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> (bus_req_o == $past(dma_req_i)));

    assert_gnt_onehot_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(ext_gnt_o));

    assert_arb_no_sack_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !role_aux_i |-> !bus_sack_o);

    assert_dcok_init_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!role_aux_i && !dcok_i) |=> bus_init_o);

    assert_aux_no_init_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        role_aux_i |-> !bus_init_o);

    assert_iack_chain_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        role_aux_i |=> (iack_out_o == $past(iack_in_i)));

    assert_arb_no_reboot_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !role_aux_i |-> !reboot_req_o);

    assert_halt_excl_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(halt_req_o && reboot_req_o));
endmodule

bind bus_role_ctrl bus_role_chk #(.NUM_EXT(NUM_EXT)) i_chk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .role_aux_i   (role_aux_i),
    .dma_req_i    (dma_req_i),
    .dcok_i       (dcok_i),
    .iack_in_i    (iack_in_i),
    .bus_req_o    (bus_req_o),
    .bus_sack_o   (bus_sack_o),
    .bus_init_o   (bus_init_o),
    .iack_out_o   (iack_out_o),
    .ext_gnt_o    (ext_gnt_o),
    .halt_req_o   (halt_req_o),
    .reboot_req_o (reboot_req_o)
);

// File: tb/test_bus_role_ctrl.sv
`timescale 1ns/1ps
module test_bus_role_ctrl;
    localparam int NE  = 3;
    localparam int NB  = 4;
    localparam int IL  = 4;
    localparam int NR  = NE + 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic role_aux = 1'b0, dma_req = 1'b0, gnt_in = 1'b0, binit = 1'b0;
    logic dcok = 1'b1, bir_wr = 1'b0, iack_in = 1'b0, iack_loc = 1'b0;
    logic [NE-1:0] ext_req = '0;
    logic [NB-1:0] irq_bus = '0;
    logic irq_tmr = 1'b0, irq_con = 1'b0, irq_db = 1'b0;
    logic bhalt = 1'b0, hen_n = 1'b1, rhalt = 1'b0;

    logic bus_req, sack, init_o, iack_out, lgnt, sclr, halt, reboot;
    logic [NE-1:0] egnt;
    logic [NB+2:0] acc;

    always #2.5 clk = ~clk;

    bus_role_ctrl #(.NUM_EXT(NE), .NUM_BUS_IRQ(NB), .INIT_LEN(IL)) i_bus_role_ctrl (
        .clk_i(clk), .rst_ni(rst_n), .role_aux_i(role_aux), .dma_req_i(dma_req),
        .ext_req_i(ext_req), .bus_gnt_in_i(gnt_in), .bus_init_i(binit), .dcok_i(dcok),
        .bir_wr_i(bir_wr), .iack_in_i(iack_in), .iack_local_i(iack_loc),
        .irq_bus_i(irq_bus), .irq_timer_i(irq_tmr), .irq_console_i(irq_con),
        .irq_doorbell_i(irq_db), .bus_halt_i(bhalt), .halt_en_n_i(hen_n),
        .reg_halt_i(rhalt), .bus_req_o(bus_req), .bus_sack_o(sack), .bus_init_o(init_o),
        .iack_out_o(iack_out), .local_gnt_o(lgnt), .ext_gnt_o(egnt), .sys_clr_o(sclr),
        .irq_acc_o(acc), .halt_req_o(halt), .reboot_req_o(reboot)
    );

    typedef struct {
        bit aux;
        bit clr_gnt;
        logic bus_req, sack, init, iack, lgnt, clr, halt, reboot;
        logic [NE-1:0] egnt;
        logic [NB+2:0] acc;
    } exp_t;

    exp_t sb_q[$];
    int n_chk = 0;
    int n_fail = 0;
    logic [NR-1:0] m_gnt = '0;
    int m_cnt = 0;

    task automatic check(string req, string nm, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, nm, act, exp);
        end
    endtask

    // driver: compute expected outputs of the coming edge from the requirements
    task automatic tick();
        exp_t e;
        logic [NR-1:0] req;
        logic [NR-1:0] ng;
        bit hon;
        req = {ext_req, dma_req};
        hon = !hen_n;
        e.aux = role_aux;
        e.bus_req = dma_req;
        if (!role_aux) begin
            if (!dcok || bir_wr) m_cnt = IL;
            else if (m_cnt > 0) m_cnt--;
            e.init = (m_cnt != 0);
            e.clr = e.init;
        end else begin
            m_cnt = 0;
            e.init = 1'b0;
            e.clr = !dcok || binit;
        end
        ng = '0;
        if (!role_aux && !e.clr) begin
            if ((m_gnt & req) != '0) ng = m_gnt;
            else for (int i = 0; i < NR; i++) if (req[i] && ng == '0) ng[i] = 1'b1;
        end
        e.clr_gnt = !role_aux && e.clr;
        m_gnt = ng;
        e.egnt = ng[NR-1:1];
        e.lgnt = role_aux ? gnt_in : ng[0];
        e.sack = role_aux && gnt_in && dma_req;
        e.iack = role_aux ? iack_in : iack_loc;
        e.acc = {irq_db, irq_con, irq_tmr, (role_aux ? {NB{1'b0}} : irq_bus)};
        e.halt = hon && (role_aux ? rhalt : bhalt);
        e.reboot = role_aux && !hon && rhalt;
        sb_q.push_back(e);
        @(negedge clk);
    endtask

    // monitor: compare after each rising edge
    always @(posedge clk) begin
        #1;
        if (rst_n && sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            check("R1", "bus_req", bus_req, e.bus_req);
            check(e.clr_gnt ? "R11" : "R2", "ext_gnt", egnt, e.egnt);
            check(e.clr_gnt ? "R11" : "R3", "local_gnt", lgnt, e.lgnt);
            check("R4", "sack", sack, e.sack);
            check(e.aux ? "R6" : "R5", "bus_init", init_o, e.init);
            check(e.aux ? "R6" : "R5", "sys_clr", sclr, e.clr);
            check("R7", "iack_out", iack_out, e.iack);
            check("R8", "irq_acc", acc, e.acc);
            check(e.aux ? "R10" : "R9", "halt", halt, e.halt);
            check(e.aux ? "R10" : "R9", "reboot", reboot, e.reboot);
        end
    end

    task automatic do_reset(bit aux);
        rst_n = 1'b0;
        role_aux = aux;
        {dma_req, gnt_in, binit, bir_wr, iack_in, iack_loc} = '0;
        {irq_tmr, irq_con, irq_db, bhalt, rhalt} = '0;
        ext_req = '0; irq_bus = '0; dcok = 1'b1; hen_n = 1'b1;
        m_gnt = '0; m_cnt = 0;
        repeat (2) @(negedge clk);
        // R1 reset state: every output low
        check("R1", "reset outputs",
              int'({bus_req, sack, init_o, iack_out, lgnt, sclr, halt, reboot, egnt, acc}), 0);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    bit done = 1'b0;

    initial begin
        @(negedge clk);
        // ---------------- arbiter role ----------------
        do_reset(1'b0);
        dma_req = 1'b1; tick();                      // R1, R3 local grant
        dma_req = 1'b0; tick();
        ext_req = 3'b110; tick();                    // R2 lowest index wins
        dma_req = 1'b1; tick();                      // R2 hold against higher priority
        ext_req = 3'b100; tick();                    // released, local wins
        ext_req = 3'b000; dma_req = 1'b0; tick();
        ext_req = 3'b001; gnt_in = 1'b1; tick();     // R3 grant-in ignored, R4 no sack
        dma_req = 1'b1; tick();
        dcok = 1'b0; tick(); tick();                 // R5 init, R11 grant dropped
        dcok = 1'b1; ext_req = '0; dma_req = 1'b0;
        repeat (IL + 1) tick();                      // R5 init tail
        gnt_in = 1'b0;
        bir_wr = 1'b1; tick(); bir_wr = 1'b0;        // R5 pulse length
        repeat (IL + 1) tick();
        iack_loc = 1'b1; iack_in = 1'b0; tick();     // R7
        iack_loc = 1'b0; iack_in = 1'b1; tick();
        iack_in = 1'b0;
        irq_bus = 4'b1010; irq_tmr = 1'b1; tick();   // R8
        irq_bus = 4'b0101; irq_tmr = 1'b0; irq_db = 1'b1; irq_con = 1'b1; tick();
        irq_bus = '0; irq_db = 1'b0; irq_con = 1'b0;
        hen_n = 1'b0; bhalt = 1'b1; tick();          // R9 bus halt counts
        bhalt = 1'b0; rhalt = 1'b1; tick();          // R9 reg halt ignored
        hen_n = 1'b1; bhalt = 1'b1; tick();          // R9 disabled halt
        bhalt = 1'b0; rhalt = 1'b0; tick();
        // ---------------- auxiliary role ----------------
        do_reset(1'b1);
        dma_req = 1'b1; tick();                      // R1, no grant yet
        gnt_in = 1'b1; tick();                       // R3, R4 sack
        ext_req = 3'b111; dma_req = 1'b0; tick();    // R2 arbitration off
        gnt_in = 1'b0; ext_req = '0; tick();
        bir_wr = 1'b1; tick(); bir_wr = 1'b0;        // R6 write ignored
        repeat (2) tick();
        binit = 1'b1; tick(); binit = 1'b0; tick();  // R6 clear from bus init
        dcok = 1'b0; tick(); dcok = 1'b1; tick();
        iack_in = 1'b1; tick();                      // R7 pass-through
        iack_loc = 1'b1; iack_in = 1'b0; tick();     // R7 local decision ignored
        iack_loc = 1'b0;
        irq_bus = 4'b1111; irq_con = 1'b1; tick();   // R8 bus lines masked
        irq_bus = '0; irq_con = 1'b0;
        hen_n = 1'b0; rhalt = 1'b1; tick();          // R10 halt
        rhalt = 1'b0; bhalt = 1'b1; tick();          // R10 bus halt ignored
        hen_n = 1'b1; bhalt = 1'b0; rhalt = 1'b1; tick();  // R10 reboot
        rhalt = 1'b0; tick();
        tick();
        done = 1'b1;
    end

    initial begin
        int cyc;
        cyc = 0;
        while (!done && cyc < 20000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=done", cyc);
        end
        #2;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule